// File: doc/BRIEF.md
# Pushbutton Wake and Reset Controller

This block watches an active-low pushbutton and measures how long it stays pressed, counting in units of an external microsecond tick. Two independently configured hold thresholds raise wake events, and a longer configured threshold raises a reset event. Every event produces a host interrupt pulse of 128 ticks. A reset event also drives a reset output for a fixed number of ticks. Each event sets a sticky status flag, and the flag stays set until the host strobes a status read.

The button is honoured only while the battery is present, or while the input supply is good and charging is enabled. It passes through a synchronizer and a debounce filter before it reaches the hold counter. The reset fires once per press. It is re-armed only after the button is released and then held again. A configuration bit can make reset also require a good input supply. At each reset the block latches a recovery request. With a good input supply the request is to resume the previous mode. With battery only, the request is ship or high-impedance mode, chosen by a configuration bit. The block also raises a system-output re-enable request when the recovery target calls for it.

All pins are plain control and status levels or strobes. No data stream crosses the boundary, so no valid/ready handshake is used.

Top module: `pbw_ctrl`

## Requirements
- R1: When neither `bat_present` nor (`vin_good` and `chg_en`) is high, the button has no effect: holding it for any time sets no flag and produces no `irq` or `rst_pulse`.
- R2: The button is synchronized and debounced. With SYNC_STAGES=2, a press first made before edge 1 and held sets a flag at edge 3+DEB_TICKS+T, where T is the threshold in ticks and a tick arrives every cycle. A low glitch shorter than DEB_TICKS ticks is ignored.
- R3: `wake1_flag` sets when the hold reaches the `cfg_wake1` threshold. Code 0/1/2/3 selects 50/100/500/1000 ms, each ms being MS_TICKS ticks.
- R4: `wake2_flag` sets in the same way from `cfg_wake2`, independently of `cfg_wake1`, using the same code table.
- R5: Each wake or reset event drives `irq` high from the same edge that sets the flag, for exactly INT_TICKS ticks.
- R6: The reset event occurs when the hold reaches the `cfg_rst` threshold. Code 0/1/2/3 selects 2000/4000/8000/10000 ms. The event sets `rst_flag` and drives `rst_pulse` high for exactly RST_TICKS ticks.
- R7: Only one reset occurs per press. Holding on gives no further pulse. A release followed by a new qualifying hold is needed before the next reset.
- R8: The wake flags and `rst_flag` stay set until `stat_rd` is high on a clock edge, which clears them. A new event on the same edge leaves its flag set.
- R9: With `cfg_rst_need_vin`=1, reset waits until `vin_good` is high while the hold threshold is met. With 0, the button hold alone suffices.
- R10: At each reset `recov_mode` latches 1 (resume) if `vin_good` is high. Otherwise it latches 2 (ship) when `cfg_recov_hiz`=0, or 3 (high impedance) when `cfg_recov_hiz`=1.
- R11: At each reset `sys_reen_req` latches `sys_off` AND (target is high impedance OR (target is resume AND `prev_idle`)).
- R12: Releasing before a threshold is reached clears the hold count. A hold of T-1 ticks sets no flag, and a hold of T ticks sets it.
- R13: After reset all flags, `irq`, `rst_pulse`, `sys_reen_req` and `recov_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle microsecond tick |
| btn_n | input | 1 | Pushbutton, active low, asynchronous |
| bat_present | input | 1 | Battery present |
| vin_good | input | 1 | Input supply inside its valid window |
| chg_en | input | 1 | Charging enabled |
| cfg_wake1 | input | 2 | Wake 1 hold code |
| cfg_wake2 | input | 2 | Wake 2 hold code |
| cfg_rst | input | 2 | Reset hold code |
| cfg_rst_need_vin | input | 1 | Reset also needs a good input supply |
| cfg_recov_hiz | input | 1 | Battery-only recovery: 0 ship, 1 high impedance |
| sys_off | input | 1 | System output currently disabled |
| prev_idle | input | 1 | Previous operating mode was idle |
| stat_rd | input | 1 | Status read strobe, clears sticky flags |
| irq | output | 1 | Host interrupt pulse |
| rst_pulse | output | 1 | Reset output pulse |
| wake1_flag | output | 1 | Sticky wake 1 flag |
| wake2_flag | output | 1 | Sticky wake 2 flag |
| rst_flag | output | 1 | Sticky reset flag |
| recov_mode | output | 2 | Recovery request: 0 none, 1 resume, 2 ship, 3 high impedance |
| sys_reen_req | output | 1 | System output re-enable request |

## Verification
With a tick on every cycle, a press made before edge 1 reaches the hold counter after the two synchronizer edges and DEB_TICKS debounce edges. A flag, the `irq` rise and any reset event then appear one edge after the count reaches the threshold, at edge 3+DEB_TICKS+T. The bench samples on the falling edge just before and just after that edge. It also checks the last high cycle and the first low cycle of each pulse, at INT_TICKS or RST_TICKS edges after the rise. A late `vin_good` takes effect on the next edge. The table-driven holds are checked only after the debounced release has settled, so their outcome does not depend on exact timing.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

  typedef enum logic [1:0] {
    RECOV_NONE   = 2'd0,
    RECOV_RESUME = 2'd1,
    RECOV_SHIP   = 2'd2,
    RECOV_HIZ    = 2'd3
  } recov_e;

  localparam int unsigned RST_MS_MAX = 10000;

  function automatic int unsigned wake_ms(input logic [1:0] code);
    int unsigned ms;
    case (code)
      2'd0:    ms = 50;
      2'd1:    ms = 100;
      2'd2:    ms = 500;
      default: ms = 1000;
    endcase
    return ms;
  endfunction

  function automatic int unsigned rst_ms(input logic [1:0] code);
    int unsigned ms;
    case (code)
      2'd0:    ms = 2000;
      2'd1:    ms = 4000;
      2'd2:    ms = 8000;
      default: ms = RST_MS_MAX;
    endcase
    return ms;
  endfunction

endpackage

// File: rtl/pbw_sync_deb.sv
module pbw_sync_deb #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_n,
  output logic pressed
);
  localparam int DW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DW-1:0]          db_cnt;
  logic                   raw_press;

  // Metastability chain, idle level is released (high).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_n};
  end

  assign raw_press = ~sync_q[SYNC_STAGES-1];

  // A level change is accepted only after DEB_TICKS consecutive ticks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_cnt  <= '0;
      pressed <= 1'b0;
    end else if (raw_press == pressed) begin
      db_cnt <= '0;
    end else if (tick) begin
      if (db_cnt == DW'(DEB_TICKS - 1)) begin
        pressed <= raw_press;
        db_cnt  <= '0;
      end else begin
        db_cnt <= db_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbw_hold_timer.sv
module pbw_hold_timer
  import pbw_pkg::*;
#(
  parameter int MS_TICKS = 1000,
  parameter int N_WAKE   = 2,
  parameter int CNT_W    = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   pressed,
  input  logic [N_WAKE-1:0][1:0] wake_code,
  input  logic [1:0]             rst_code,
  output logic [N_WAKE-1:0]      wake_evt,
  output logic                   rst_reached,
  output logic [CNT_W-1:0]       cnt
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(RST_MS_MAX * MS_TICKS);

  logic             inc;
  logic [CNT_W-1:0] rst_thr;

  assign inc = pressed && tick && (cnt != SAT);

  // Hold counter: cleared whenever the qualified button is released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!pressed) cnt <= '0;
    else if (inc)      cnt <= cnt + 1'b1;
  end

  // One crossing detector per wake channel.
  for (genvar w = 0; w < N_WAKE; w++) begin : g_wake
    logic [CNT_W-1:0] thr;
    logic             evt_q;
    assign thr = CNT_W'(wake_ms(wake_code[w]) * MS_TICKS);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= inc && (cnt == thr - 1'b1);
    end
    assign wake_evt[w] = evt_q;
  end

  assign rst_thr     = CNT_W'(rst_ms(rst_code) * MS_TICKS);
  assign rst_reached = (cnt >= rst_thr);

endmodule

// File: rtl/pbw_pulse.sv
module pbw_pulse #(
  parameter int WIDTH_TICKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trig,
  output logic active
);
  localparam int PW = $clog2(WIDTH_TICKS + 1);

  logic [PW-1:0] remain;

  // A trigger (re)loads the full width; each tick afterwards consumes one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      remain <= '0;
    else if (trig)                   remain <= PW'(WIDTH_TICKS);
    else if (tick && remain != '0)   remain <= remain - 1'b1;
  end

  assign active = (remain != '0);

endmodule

// File: rtl/pbw_ctrl.sv
module pbw_ctrl
  import pbw_pkg::*;
#(
  parameter int MS_TICKS    = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 8,
  parameter int INT_TICKS   = 128,
  parameter int RST_TICKS   = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       btn_n,
  input  logic       bat_present,
  input  logic       vin_good,
  input  logic       chg_en,
  input  logic [1:0] cfg_wake1,
  input  logic [1:0] cfg_wake2,
  input  logic [1:0] cfg_rst,
  input  logic       cfg_rst_need_vin,
  input  logic       cfg_recov_hiz,
  input  logic       sys_off,
  input  logic       prev_idle,
  input  logic       stat_rd,
  output logic       irq,
  output logic       rst_pulse,
  output logic       wake1_flag,
  output logic       wake2_flag,
  output logic       rst_flag,
  output logic [1:0] recov_mode,
  output logic       sys_reen_req
);
  localparam int N_WAKE = 2;
  localparam int CNT_W  = $clog2(RST_MS_MAX * MS_TICKS + 1);

  logic                   db_pressed;
  logic                   qual_en;
  logic                   press_q;
  logic [N_WAKE-1:0][1:0] wake_code;
  logic [N_WAKE-1:0]      evt_w;
  logic                   rst_reached;
  logic [CNT_W-1:0]       hold_cnt;
  logic                   armed;
  logic                   rst_gate;
  logic                   rst_fire;
  logic                   irq_trig;
  logic [N_WAKE-1:0]      wake_flag_q;
  recov_e                 recov_q;
  recov_e                 recov_next;

  assign qual_en = bat_present | (vin_good & chg_en);
  assign press_q = db_pressed & qual_en;

  pbw_sync_deb #(
    .SYNC_STAGES (SYNC_STAGES),
    .DEB_TICKS   (DEB_TICKS)
  ) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_us),
    .btn_n   (btn_n),
    .pressed (db_pressed)
  );

  assign wake_code[0] = cfg_wake1;
  assign wake_code[1] = cfg_wake2;

  pbw_hold_timer #(
    .MS_TICKS (MS_TICKS),
    .N_WAKE   (N_WAKE),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_us),
    .pressed     (press_q),
    .wake_code   (wake_code),
    .rst_code    (cfg_rst),
    .wake_evt    (evt_w),
    .rst_reached (rst_reached),
    .cnt         (hold_cnt)
  );

  // Reset arming: one shot per press, re-armed by a qualified release.
  assign rst_gate = ~cfg_rst_need_vin | vin_good;
  assign rst_fire = armed & rst_reached & rst_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b1;
    else if (rst_fire) armed <= 1'b0;
    else if (!press_q) armed <= 1'b1;
  end

  // Sticky flags: a same-edge event dominates the read clear.
  for (genvar w = 0; w < N_WAKE; w++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_flag_q[w] <= 1'b0;
      else        wake_flag_q[w] <= (wake_flag_q[w] & ~stat_rd) | evt_w[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_flag <= 1'b0;
    else        rst_flag <= (rst_flag & ~stat_rd) | rst_fire;
  end

  assign wake1_flag = wake_flag_q[0];
  assign wake2_flag = wake_flag_q[1];

  // Pulse outputs.
  assign irq_trig = (|evt_w) | rst_fire;

  pbw_pulse #(.WIDTH_TICKS(INT_TICKS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_us),
    .trig   (irq_trig),
    .active (irq)
  );

  pbw_pulse #(.WIDTH_TICKS(RST_TICKS)) u_rstp (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_us),
    .trig   (rst_fire),
    .active (rst_pulse)
  );

  // Recovery request latched at each reset.
  always_comb begin
    if (vin_good)           recov_next = RECOV_RESUME;
    else if (cfg_recov_hiz) recov_next = RECOV_HIZ;
    else                    recov_next = RECOV_SHIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recov_q      <= RECOV_NONE;
      sys_reen_req <= 1'b0;
    end else if (rst_fire) begin
      recov_q      <= recov_next;
      sys_reen_req <= sys_off & ((recov_next == RECOV_HIZ) |
                                 ((recov_next == RECOV_RESUME) & prev_idle));
    end
  end

  assign recov_mode = recov_q;

endmodule

// File: rtl/pbw_ctrl_chk.sv
module pbw_ctrl_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stat_rd,
  input logic             vin_good,
  input logic             cfg_rst_need_vin,
  input logic             qual_en,
  input logic             armed,
  input logic [1:0]       evt_w,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             irq,
  input logic             rst_pulse,
  input logic             wake1_flag,
  input logic             wake2_flag,
  input logic             rst_flag,
  input logic [1:0]       recov_mode
);

  p_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_en |=> (hold_cnt == '0));

  p_irq_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (wake1_flag || wake2_flag || rst_flag));

  p_rst_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> (rst_flag && irq));

  p_rst_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> !armed);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_rd) && !$past(evt_w[0])) |-> !wake1_flag);

  p_vin_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_pulse) && $past(cfg_rst_need_vin)) |-> $past(vin_good));

  p_recov_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> (recov_mode != 2'd0));

endmodule

bind pbw_ctrl pbw_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .stat_rd          (stat_rd),
  .vin_good         (vin_good),
  .cfg_rst_need_vin (cfg_rst_need_vin),
  .qual_en          (qual_en),
  .armed            (armed),
  .evt_w            (evt_w),
  .hold_cnt         (hold_cnt),
  .irq              (irq),
  .rst_pulse        (rst_pulse),
  .wake1_flag       (wake1_flag),
  .wake2_flag       (wake2_flag),
  .rst_flag         (rst_flag),
  .recov_mode       (recov_mode)
);

// File: tb/pbw_ctrl_tb.sv
module pbw_ctrl_tb;
  localparam int DEB = 4;
  localparam int INTW = 128;
  localparam int RSTW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic btn_n = 1'b1;
  logic bat_present = 1'b1, vin_good = 1'b0, chg_en = 1'b0;
  logic [1:0] cfg_wake1 = 2'd0, cfg_wake2 = 2'd3, cfg_rst = 2'd3;
  logic cfg_rst_need_vin = 1'b0, cfg_recov_hiz = 1'b0;
  logic sys_off = 1'b0, prev_idle = 1'b0, stat_rd = 1'b0;
  logic irq, rst_pulse, wake1_flag, wake2_flag, rst_flag, sys_reen_req;
  logic [1:0] recov_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pbw_ctrl #(
    .MS_TICKS(1), .SYNC_STAGES(2), .DEB_TICKS(DEB),
    .INT_TICKS(INTW), .RST_TICKS(RSTW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .btn_n(btn_n),
    .bat_present(bat_present), .vin_good(vin_good), .chg_en(chg_en),
    .cfg_wake1(cfg_wake1), .cfg_wake2(cfg_wake2), .cfg_rst(cfg_rst),
    .cfg_rst_need_vin(cfg_rst_need_vin), .cfg_recov_hiz(cfg_recov_hiz),
    .sys_off(sys_off), .prev_idle(prev_idle), .stat_rd(stat_rd),
    .irq(irq), .rst_pulse(rst_pulse), .wake1_flag(wake1_flag),
    .wake2_flag(wake2_flag), .rst_flag(rst_flag), .recov_mode(recov_mode),
    .sys_reen_req(sys_reen_req)
  );

  // {wake1 code, wake2 code, hold edges}
  localparam logic [13:0] VEC [0:7] = '{
    {2'd0, 2'd1, 10'd49},  {2'd0, 2'd1, 10'd50},
    {2'd1, 2'd0, 10'd99},  {2'd1, 2'd0, 10'd100},
    {2'd2, 2'd0, 10'd300}, {2'd0, 2'd2, 10'd520},
    {2'd3, 2'd2, 10'd600}, {2'd2, 2'd3, 10'd1023}
  };

  function automatic int exp_wake(input logic [1:0] c);
    case (c)
      2'd0: return 50;
      2'd1: return 100;
      2'd2: return 500;
      default: return 1000;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_clr();
    stat_rd = 1'b1;
    adv(1);
    stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    adv(3);
    rst_n = 1'b1;
    adv(2);
    // R13 reset state
    chk("R13 irq", irq, 0);
    chk("R13 rst_pulse", rst_pulse, 0);
    chk("R13 flags", {wake1_flag, wake2_flag, rst_flag}, 0);
    chk("R13 recov_mode", recov_mode, 0);
    chk("R13 sys_reen_req", sys_reen_req, 0);

    // Table walk: R3 R4 R12
    for (int i = 0; i < 8; i++) begin
      logic [1:0] w1c, w2c;
      int hold;
      w1c = VEC[i][13:12];
      w2c = VEC[i][11:10];
      hold = int'(VEC[i][9:0]);
      cfg_wake1 = w1c;
      cfg_wake2 = w2c;
      btn_n = 1'b0;
      adv(hold);
      btn_n = 1'b1;
      adv(30);
      chk($sformatf("R3 R12 vec%0d wake1", i), wake1_flag, int'(hold >= exp_wake(w1c)));
      chk($sformatf("R4 R12 vec%0d wake2", i), wake2_flag, int'(hold >= exp_wake(w2c)));
      read_clr();
      adv(140);
    end
    chk("R8 cleared after table", {wake1_flag, wake2_flag}, 0);

    // Exact timing R2 R3 R5, same-edge read R8
    cfg_wake1 = 2'd0;
    cfg_wake2 = 2'd3;
    btn_n = 1'b0;
    adv(3 + DEB + 50 - 1);
    chk("R2 wake1 not yet", wake1_flag, 0);
    chk("R5 irq not yet", irq, 0);
    stat_rd = 1'b1;
    adv(1);
    stat_rd = 1'b0;
    btn_n = 1'b1;
    chk("R2 R8 wake1 set despite read", wake1_flag, 1);
    chk("R5 irq rises", irq, 1);
    adv(INTW - 1);
    chk("R5 irq last high", irq, 1);
    adv(1);
    chk("R5 irq low after width", irq, 0);
    chk("R8 flag still sticky", wake1_flag, 1);
    read_clr();
    chk("R8 read clears", wake1_flag, 0);
    adv(20);

    // Glitch R2
    btn_n = 1'b0;
    adv(2);
    btn_n = 1'b1;
    adv(200);
    chk("R2 glitch no flag", wake1_flag, 0);
    chk("R2 glitch no irq", irq, 0);

    // Disabled qualifier R1
    bat_present = 1'b0;
    vin_good = 1'b0;
    chg_en = 1'b1;
    btn_n = 1'b0;
    adv(300);
    chk("R1 no flag", wake1_flag, 0);
    chk("R1 no irq", irq, 0);
    btn_n = 1'b1;
    adv(20);
    bat_present = 1'b1;
    chg_en = 1'b0;

    // Reset, battery only, ship: R6 R10 R11
    cfg_rst = 2'd0;
    sys_off = 1'b1;
    cfg_recov_hiz = 1'b0;
    btn_n = 1'b0;
    adv(3 + DEB + 2000 - 1);
    chk("R6 rst not yet", rst_pulse, 0);
    adv(1);
    chk("R6 rst_pulse rises", rst_pulse, 1);
    chk("R6 rst_flag", rst_flag, 1);
    chk("R10 ship", recov_mode, 2);
    chk("R11 no reenable for ship", sys_reen_req, 0);
    adv(RSTW - 1);
    chk("R6 rst last high", rst_pulse, 1);
    adv(1);
    chk("R6 rst low after width", rst_pulse, 0);
    adv(900);
    chk("R7 no second pulse", rst_pulse, 0);
    btn_n = 1'b1;
    adv(20);
    read_clr();
    chk("R8 rst_flag cleared", rst_flag, 0);

    // Re-armed reset, high impedance: R7 R10 R11
    cfg_recov_hiz = 1'b1;
    btn_n = 1'b0;
    adv(3 + DEB + 2000);
    chk("R7 rearmed reset", rst_pulse, 1);
    chk("R10 hiz", recov_mode, 3);
    chk("R11 reenable for hiz", sys_reen_req, 1);
    btn_n = 1'b1;
    adv(100);
    read_clr();

    // Input supply gate: R9 R10 R11
    cfg_rst_need_vin = 1'b1;
    prev_idle = 1'b1;
    btn_n = 1'b0;
    adv(2100);
    chk("R9 gated no reset", rst_pulse, 0);
    chk("R9 gated no flag", rst_flag, 0);
    vin_good = 1'b1;
    adv(1);
    chk("R9 reset with vin", rst_pulse, 1);
    chk("R10 resume", recov_mode, 1);
    chk("R11 reenable idle resume", sys_reen_req, 1);
    btn_n = 1'b1;
    adv(100);

    finish_run();
  end

endmodule